// File: doc/BRIEF.md
# Automatic UART Flow Controller

This block sits beside the transmit and receive paths of a UART with 128-entry FIFOs and handles flow control with no help from the host. On the receive side it watches the receive FIFO fill level against two programmable thresholds. When the level climbs to the upper threshold, the block marks the link as throttled. When the level sinks to the lower threshold, it releases it. While throttled, it raises the active-low RTS and/or DTR outputs to their inactive level. It also asks the transmit shifter to send one XOFF character, and one XON character once the throttle is released.

Characters arriving from the receive shifter pass through the block on a valid/ready stream on their way into the receive FIFO. When in-band receive control is on, XON and XOFF characters are taken out of that stream and not forwarded: XOFF pauses the transmitter and XON resumes it. The CTS and DSR modem inputs are active low and are synchronised through two flops. When enabled, either one can stall the transmitter. The block never cuts a character already in the shifter: it only grants or withholds permission to load the next FIFO character. An inserted XON/XOFF character is offered ahead of that next FIFO character.

Stream rules: `rx_in_valid`/`rx_in_ready` and `rx_out_valid`/`rx_out_ready` follow the usual rule that a beat moves when valid and ready are both high. A forwarded character waits on `rx_out_ready`. A consumed XON/XOFF is accepted at once. `ins_valid` stays high until `ins_ready` is seen. It drops early only if the throttle state flips back or in-band transmit control is switched off, because the character is then no longer wanted.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, `tx_allow` is 1, `ins_valid` is 0, `rts_n` and `dtr_n` are 0, and all four status bits are 0.
- R2: `stat_throttled` becomes 1 one cycle after `rx_level >= cfg_hi_level`. It becomes 0 one cycle after `rx_level <= cfg_lo_level` when the upper condition is false. Otherwise it holds. The upper condition wins when both are true.
- R3: `rts_n` equals `stat_throttled` when `cfg_rts_en` is 1 and is 0 otherwise. `dtr_n` behaves the same way under `cfg_dtr_en`.
- R4: With `cfg_ins_en` set, `ins_valid` is 1 whenever `stat_throttled` differs from `stat_xoff_sent`. At those times `ins_data` is `cfg_xoff_char` if throttled and `cfg_xon_char` if not. On the cycle after `ins_valid && ins_ready`, `stat_xoff_sent` takes the throttle value that was accepted.
- R5: While `ins_valid` is 1, `tx_allow` is 0, so the inserted character goes ahead of any FIFO character.
- R6: With `cfg_rxctl_en` set, an accepted `rx_in_data == cfg_xoff_char` sets `stat_remote_paused` on the next cycle, and `cfg_xon_char` clears it. XOFF wins if both characters are the same value. While paused, `tx_allow` is 0.
- R7: With `cfg_rxctl_en` set, an XON or XOFF character gives `rx_out_valid` 0 and `rx_in_ready` 1. Every other character gives `rx_out_valid = rx_in_valid`, `rx_out_data = rx_in_data` and `rx_in_ready = rx_out_ready`.
- R8: With `cfg_cts_en` set, `cts_n` high stalls the transmitter: `tx_allow` and `stat_hw_stall` change on the second clock edge after `cts_n` changes. `dsr_n` does the same under `cfg_dsr_en`. A disabled input has no effect.
- R9: With `cfg_rxctl_en` clear, XON/XOFF characters are forwarded like any other character, and `stat_remote_paused` is 0 from the next cycle.
- R10: With `cfg_ins_en` clear, `ins_valid` is 0 and `stat_xoff_sent` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ins_en | input | 1 | Enable automatic XON/XOFF transmission |
| cfg_rxctl_en | input | 1 | Enable honouring of received XON/XOFF |
| cfg_rts_en | input | 1 | Drive RTS from the throttle state |
| cfg_dtr_en | input | 1 | Drive DTR from the throttle state |
| cfg_cts_en | input | 1 | Let CTS stall the transmitter |
| cfg_dsr_en | input | 1 | Let DSR stall the transmitter |
| cfg_xon_char | input | 8 | XON character value |
| cfg_xoff_char | input | 8 | XOFF character value |
| cfg_hi_level | input | 8 | Upper fill threshold |
| cfg_lo_level | input | 8 | Lower fill threshold |
| rx_level | input | 8 | Receive FIFO fill level, 0 to 128 |
| rx_in_valid | input | 1 | Received character valid |
| rx_in_data | input | 8 | Received character |
| rx_in_ready | output | 1 | Received character accepted |
| rx_out_valid | output | 1 | Character for the receive FIFO valid |
| rx_out_data | output | 8 | Character for the receive FIFO |
| rx_out_ready | input | 1 | Receive FIFO can accept |
| ins_valid | output | 1 | Request to send a flow character |
| ins_data | output | 8 | Flow character to send |
| ins_ready | input | 1 | Shifter takes the flow character |
| tx_allow | output | 1 | Shifter may load the next FIFO character |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| stat_throttled | output | 1 | Local receive side throttled |
| stat_xoff_sent | output | 1 | Last flow character sent was XOFF |
| stat_remote_paused | output | 1 | Remote XOFF in force |
| stat_hw_stall | output | 1 | CTS/DSR holding the transmitter |

## Verification
Each result has a fixed delay from its stimulus. The throttle state, RTS/DTR, the insert request and its status bit follow a fill-level or handshake change after one clock edge. The remote pause follows an accepted receive character after one edge. A CTS or DSR change reaches `tx_allow` after two edges, through the synchroniser. The stream outputs `rx_out_valid`, `rx_in_ready` and the gating of `tx_allow` by `ins_valid` are combinational in the same cycle. The bench's reference model applies each input at the clock edge where the design registers it, using the same delays. It drives inputs on the falling edge and compares every output a short settle time later. Each result is therefore checked in exactly the cycle it is due.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int FIFO_DEPTH_DEF = 128;
  localparam int CHAR_W_DEF     = 8;

  typedef struct packed {
    logic throttled;
    logic xoff_sent;
    logic remote_paused;
    logic hw_stall;
  } flow_status_t;
endpackage

// File: rtl/flow_sync.sv
module flow_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/flow_level_watch.sv
module flow_level_watch #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] hi_level,
  input  logic [LVL_W-1:0] lo_level,
  output logic             throttled
);
  logic at_hi, at_lo;

  assign at_hi = (level >= hi_level);
  assign at_lo = (level <= lo_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     throttled <= 1'b0;
    else if (at_hi) throttled <= 1'b1;
    else if (at_lo) throttled <= 1'b0;
  end
endmodule

// File: rtl/flow_rx_filter.sv
module flow_rx_filter #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  input  logic              out_ready,
  output logic              paused
);
  logic is_xoff, is_xon, consume;

  assign is_xoff  = (in_data == xoff_char);
  assign is_xon   = (in_data == xon_char);
  assign consume  = enable && (is_xoff || is_xon);

  assign out_valid = in_valid && !consume;
  assign out_data  = in_data;
  assign in_ready  = consume || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   paused <= 1'b0;
    else if (!enable)             paused <= 1'b0;
    else if (in_valid && consume) paused <= is_xoff;
  end
endmodule

// File: rtl/flow_tx_insert.sv
module flow_tx_insert #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              throttled,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  output logic              ins_valid,
  output logic [CHAR_W-1:0] ins_data,
  input  logic              ins_ready,
  output logic              xoff_sent
);
  assign ins_valid = enable && (throttled != xoff_sent);
  assign ins_data  = throttled ? xoff_char : xon_char;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      xoff_sent <= 1'b0;
    else if (!enable)                xoff_sent <= 1'b0;
    else if (ins_valid && ins_ready) xoff_sent <= throttled;
  end
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
  parameter int FIFO_DEPTH  = flow_pkg::FIFO_DEPTH_DEF,
  parameter int CHAR_W      = flow_pkg::CHAR_W_DEF,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ins_en,
  input  logic              cfg_rxctl_en,
  input  logic              cfg_rts_en,
  input  logic              cfg_dtr_en,
  input  logic              cfg_cts_en,
  input  logic              cfg_dsr_en,
  input  logic [CHAR_W-1:0] cfg_xon_char,
  input  logic [CHAR_W-1:0] cfg_xoff_char,
  input  logic [LVL_W-1:0]  cfg_hi_level,
  input  logic [LVL_W-1:0]  cfg_lo_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_in_valid,
  input  logic [CHAR_W-1:0] rx_in_data,
  output logic              rx_in_ready,
  output logic              rx_out_valid,
  output logic [CHAR_W-1:0] rx_out_data,
  input  logic              rx_out_ready,
  output logic              ins_valid,
  output logic [CHAR_W-1:0] ins_data,
  input  logic              ins_ready,
  output logic              tx_allow,
  input  logic              cts_n,
  input  logic              dsr_n,
  output logic              rts_n,
  output logic              dtr_n,
  output logic              stat_throttled,
  output logic              stat_xoff_sent,
  output logic              stat_remote_paused,
  output logic              stat_hw_stall
);
  import flow_pkg::*;

  flow_status_t st;
  logic [1:0]   modem_raw, modem_sync;

  flow_level_watch #(.LVL_W(LVL_W)) u_level (
    .clk(clk), .rst_n(rst_n), .level(rx_level),
    .hi_level(cfg_hi_level), .lo_level(cfg_lo_level),
    .throttled(st.throttled)
  );

  flow_rx_filter #(.CHAR_W(CHAR_W)) u_rxf (
    .clk(clk), .rst_n(rst_n), .enable(cfg_rxctl_en),
    .xon_char(cfg_xon_char), .xoff_char(cfg_xoff_char),
    .in_valid(rx_in_valid), .in_data(rx_in_data), .in_ready(rx_in_ready),
    .out_valid(rx_out_valid), .out_data(rx_out_data), .out_ready(rx_out_ready),
    .paused(st.remote_paused)
  );

  flow_tx_insert #(.CHAR_W(CHAR_W)) u_ins (
    .clk(clk), .rst_n(rst_n), .enable(cfg_ins_en), .throttled(st.throttled),
    .xon_char(cfg_xon_char), .xoff_char(cfg_xoff_char),
    .ins_valid(ins_valid), .ins_data(ins_data), .ins_ready(ins_ready),
    .xoff_sent(st.xoff_sent)
  );

  assign modem_raw = {dsr_n, cts_n};

  flow_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(modem_raw), .q(modem_sync)
  );

  assign st.hw_stall = (cfg_cts_en && modem_sync[0]) || (cfg_dsr_en && modem_sync[1]);

  assign tx_allow = !st.hw_stall && !st.remote_paused && !ins_valid;
  assign rts_n    = cfg_rts_en && st.throttled;
  assign dtr_n    = cfg_dtr_en && st.throttled;

  assign stat_throttled     = st.throttled;
  assign stat_xoff_sent     = st.xoff_sent;
  assign stat_remote_paused = st.remote_paused;
  assign stat_hw_stall      = st.hw_stall;
endmodule

// File: rtl/flow_checks.sv
module flow_checks #(
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_ins_en,
  input logic              cfg_rxctl_en,
  input logic              cfg_cts_en,
  input logic [CHAR_W-1:0] cfg_xon_char,
  input logic [CHAR_W-1:0] cfg_xoff_char,
  input logic [LVL_W-1:0]  cfg_hi_level,
  input logic [LVL_W-1:0]  cfg_lo_level,
  input logic [LVL_W-1:0]  rx_level,
  input logic              rx_in_valid,
  input logic [CHAR_W-1:0] rx_in_data,
  input logic              rx_in_ready,
  input logic              rx_out_valid,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic              tx_allow,
  input logic              cts_n,
  input logic              stat_throttled,
  input logic              stat_remote_paused
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |-> (!ins_valid && !stat_remote_paused && !stat_throttled));

  p_throttle_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= cfg_hi_level) |=> stat_throttled);

  p_throttle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level <= cfg_lo_level && rx_level < cfg_hi_level) |=> !stat_throttled);

  p_ins_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready) |=> (ins_valid || !$stable(stat_throttled) || !cfg_ins_en));

  p_ins_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> !tx_allow);

  p_xoff_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && cfg_rxctl_en && rx_in_data == cfg_xoff_char) |=> !tx_allow);

  p_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && cfg_rxctl_en &&
     (rx_in_data == cfg_xoff_char || rx_in_data == cfg_xon_char))
    |-> (!rx_out_valid && rx_in_ready));

  p_cts_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cts_n && $past(cts_n) && cfg_cts_en) |=> (!tx_allow || !cfg_cts_en));
endmodule

bind uart_flow_ctrl flow_checks u_flow_checks (.*);

// File: tb/uart_flow_ctrl_tb_top.sv
module uart_flow_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       ins_en = 0, rxctl_en = 0, rts_en = 0, dtr_en = 0, cts_en = 0, dsr_en = 0;
  logic [7:0] xon_c = 8'h11, xoff_c = 8'h13, hi_l = 8'd96, lo_l = 8'd32, level = 0;
  logic       in_valid = 0, out_ready = 1, ins_ready = 0, cts = 0, dsr = 0;
  logic [7:0] in_data = 0;

  logic       in_ready, out_valid, ins_valid, tx_allow, rts_n, dtr_n;
  logic [7:0] out_data, ins_data;
  logic       s_thr, s_sent, s_pause, s_hw;

  uart_flow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_ins_en(ins_en), .cfg_rxctl_en(rxctl_en), .cfg_rts_en(rts_en), .cfg_dtr_en(dtr_en),
    .cfg_cts_en(cts_en), .cfg_dsr_en(dsr_en), .cfg_xon_char(xon_c), .cfg_xoff_char(xoff_c),
    .cfg_hi_level(hi_l), .cfg_lo_level(lo_l), .rx_level(level),
    .rx_in_valid(in_valid), .rx_in_data(in_data), .rx_in_ready(in_ready),
    .rx_out_valid(out_valid), .rx_out_data(out_data), .rx_out_ready(out_ready),
    .ins_valid(ins_valid), .ins_data(ins_data), .ins_ready(ins_ready), .tx_allow(tx_allow),
    .cts_n(cts), .dsr_n(dsr), .rts_n(rts_n), .dtr_n(dtr_n),
    .stat_throttled(s_thr), .stat_xoff_sent(s_sent),
    .stat_remote_paused(s_pause), .stat_hw_stall(s_hw)
  );

  // behavioural reference state
  bit m_thr, m_sent, m_pause;
  bit cts_q[$], dsr_q[$];
  int applied = 0, bad = 0, cycles = 0;
  bit done = 0;

  function automatic bit f_consume();
    return rxctl_en && in_valid && (in_data == xon_c || in_data == xoff_c);
  endfunction
  function automatic bit f_ins_valid();
    return ins_en && (m_thr != m_sent);
  endfunction
  function automatic bit f_hw();
    return (cts_en && cts_q[1]) || (dsr_en && dsr_q[1]);
  endfunction

  always @(posedge clk) begin
    bit iv, acc;
    if (!rst_n) begin
      m_thr = 0; m_sent = 0; m_pause = 0;
      cts_q = '{0, 0}; dsr_q = '{0, 0};
    end else begin
      iv  = f_ins_valid();
      acc = in_valid && (f_consume() || out_ready);
      if (!ins_en) m_sent = 0;
      else if (iv && ins_ready) m_sent = m_thr;
      if (!rxctl_en) m_pause = 0;
      else if (acc && in_data == xoff_c) m_pause = 1;
      else if (acc && in_data == xon_c) m_pause = 0;
      if (level >= hi_l) m_thr = 1;
      else if (level <= lo_l) m_thr = 0;
      cts_q.push_front(cts); void'(cts_q.pop_back());
      dsr_q.push_front(dsr); void'(dsr_q.pop_back());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FIFO FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // compare all outputs against the model
  task automatic compare();
    bit iv, hw;
    iv = f_ins_valid();
    hw = f_hw();
    chk("R2 throttled", s_thr, m_thr);
    chk("R3 rts_n", rts_n, rts_en && m_thr);
    chk("R3 dtr_n", dtr_n, dtr_en && m_thr);
    chk("R4/R10 ins_valid", ins_valid, iv);
    if (iv) chk("R4 ins_data", ins_data, m_thr ? xoff_c : xon_c);
    chk("R4/R10 xoff_sent", s_sent, m_sent);
    chk("R6/R9 remote_paused", s_pause, m_pause);
    chk("R8 hw_stall", s_hw, hw);
    chk("R5/R6/R8 tx_allow", tx_allow, !hw && !m_pause && !iv);
    chk("R7 rx_out_valid", out_valid, in_valid && !f_consume());
    chk("R7 rx_in_ready", in_ready, f_consume() || out_ready);
    if (out_valid) chk("R7 rx_out_data", out_data, in_data);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1 compare();
    end
  endtask

  task automatic rx_char(input logic [7:0] c);
    in_valid = 1; in_data = c;
    step(1);
    in_valid = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      summary();
    end
  end

  initial begin
    // R1: reset state
    step(3);
    chk("R1 tx_allow", tx_allow, 1);
    chk("R1 ins_valid", ins_valid, 0);
    chk("R1 rts_n", rts_n, 0);
    chk("R1 status", {s_thr, s_sent, s_pause, s_hw}, 0);
    rst_n = 1;
    step(2);

    // R2/R3/R4/R5: rise to upper threshold, XOFF held until accepted
    ins_en = 1; rts_en = 1; dtr_en = 1;
    level = 8'd95; step(2);
    level = 8'd96; step(1);
    step(3);
    ins_ready = 1; step(1);
    ins_ready = 0; step(2);
    // R2: between thresholds holds
    level = 8'd50; step(3);
    // fall to lower threshold, XON
    level = 8'd32; step(2);
    ins_ready = 1; step(2);
    ins_ready = 0;
    // R4: withdrawn request when throttle flips back
    level = 8'd128; step(2);
    level = 8'd0; step(3);

    // R6/R7: in-band receive
    rxctl_en = 1;
    rx_char(8'h41);
    rx_char(xoff_c); step(2);
    out_ready = 0; rx_char(8'h42); rx_char(xoff_c);
    out_ready = 1;
    rx_char(xon_c); step(2);
    // R6: equal characters, XOFF wins
    xon_c = 8'h13; rx_char(8'h13); step(1);
    xon_c = 8'h11; rx_char(xon_c); step(1);

    // R9: receive control off
    rx_char(xoff_c);
    rxctl_en = 0; step(1);
    rx_char(xoff_c); rx_char(xon_c); step(1);

    // R8: CTS and DSR
    cts = 1; step(4);
    cts_en = 1; step(3);
    cts = 0; step(3);
    dsr = 1; step(3);
    dsr_en = 1; step(3);
    cts = 1; step(1); dsr = 0; step(4);
    cts = 0; step(3);
    cts_en = 0; dsr_en = 0;

    // R10: insertion disabled clears sent state
    level = 8'd100; step(2);
    ins_ready = 1; step(2);
    ins_en = 0; step(3);
    ins_ready = 0;
    ins_en = 1; step(3);
    ins_ready = 1; step(2);

    // R2: hi == lo, upper wins
    hi_l = 8'd40; lo_l = 8'd40;
    level = 8'd40; step(3);
    level = 8'd39; step(3);
    rts_en = 0; dtr_en = 0; level = 8'd120; step(3);
    step(2);
    summary();
  end
endmodule